// File: doc/BRIEF.md
# Level-Priority Interrupt Entry Sequencer

This block sits beside a processor core and turns a 4-bit external interrupt request level into a complete exception entry. The request level is registered every cycle as the pending level. At each instruction boundary that the core marks as outside a branch delay slot, the pending level is compared with the 4-bit mask field of the status register (SR bits 7:4). A level above the mask is accepted. A level at or below the mask, including level 0, which means no request, is ignored.

On acceptance the block takes a snapshot of PC, SR, stack pointer and vector base, and raises a one-cycle acknowledge that carries the level. It then drives a 32-bit valid/ready bus master through three accesses. It stores the old SR just below the stack pointer, stores the interrupted PC below that, and reads the handler address from the vector table. When the sequence ends it presents the new PC, the new SR with the mask field raised to the accepted level, and the stack pointer lowered by 8. A done pulse in the last busy cycle marks the moment the core should load them. The block is busy for a fixed 13 cycles when the bus has no wait states.

Top module: `irq_entry_seq`

## Requirements
- R1: A pending level L is accepted only when L is greater than SR[7:4]; for L <= SR[7:4] (so always for L = 0) there is no busy, no acknowledge and no bus access.
- R2: The vector number is 64 + floor(L/2), and the single read of the entry goes to address VBR + 4*vector.
- R3: The first bus access is a write (we=1) of the old SR to SP-4, the second a write of the old PC to SP-8; new_sp equals SP-8.
- R4: new_sr equals the old SR with bits 7:4 replaced by L and every other bit unchanged.
- R5: new_pc equals the 32-bit word returned by the vector read.
- R6: Acceptance needs boundary=1 and in_delay_slot=0 in the evaluating cycle; while either blocks it, the request stays pending and is taken at the first qualifying boundary.
- R7: With ready returned in the cycle of each request, busy is high for exactly 13 consecutive cycles; each wait cycle on an access adds one busy cycle.
- R8: ack is high for exactly one cycle, the first busy cycle, and ack_level then equals L; done is high in the last busy cycle only.
- R9: While bus_valid is high and bus_ready low, bus_valid, bus_addr, bus_wdata and bus_we hold their values.
- R10: A request raised during an entry is not started until the entry ends; it is then evaluated against the SR the core presents.
- R11: A synchronous active-low reset clears the pending level, busy, ack, done, bus_valid and the new_pc, new_sr and new_sp outputs (all zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_level | input | 4 | External request level, 0 = none |
| boundary | input | 1 | Core is at an instruction boundary |
| in_delay_slot | input | 1 | Boundary lies inside a branch delay slot |
| cur_pc | input | 32 | PC of the instruction to resume |
| cur_sr | input | 32 | Current status register |
| cur_sp | input | 32 | Current stack pointer |
| vbr | input | 32 | Vector table base |
| bus_valid | output | 1 | Bus request |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_ready | input | 1 | Bus completes the access this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| busy | output | 1 | Entry in progress |
| ack | output | 1 | Acknowledge pulse |
| ack_level | output | 4 | Accepted level during ack, else 0 |
| done | output | 1 | Last busy cycle; new_* valid |
| new_pc | output | 32 | Handler address |
| new_sr | output | 32 | SR after entry |
| new_sp | output | 32 | Stack pointer after entry |

## Verification
A level driven before clock edge E0 is registered at E0 and evaluated in the following cycle. With a qualifying boundary, busy and ack appear right after E1, and the three bus accesses follow, one per cycle with zero wait states. done and the new_* values show up in the 13th busy cycle. The bench drives inputs on falling edges and samples every output on falling edges in a cycle-by-cycle loop. It counts busy cycles, catches the one ack, logs each completed bus handshake in order, and reads new_* in the cycle where done is seen. A masked or blocked request is held for several cycles while the bench confirms that busy and ack stay low.

// File: rtl/irq_entry_pkg.sv
// Shared types for the interrupt entry sequencer.
// Assumes: one entry is in flight at a time.
package irq_entry_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_PUSH_SR,
        ST_PUSH_PC,
        ST_FETCH,
        ST_TAIL
    } entry_state_t;
endpackage

// File: rtl/irq_pending_gate.sv
// Registers the request level each cycle and decides whether to accept it.
// Assumes: boundary/in_delay_slot/cur_sr are valid in the cycle they are sampled.
module irq_pending_gate #(
    parameter int LVL_W    = 4,
    parameter int XLEN     = 32,
    parameter int MASK_LSB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] irq_level,
    input  logic             boundary,
    input  logic             in_delay_slot,
    input  logic             idle,
    input  logic [XLEN-1:0]  cur_sr,
    output logic [LVL_W-1:0] pend_level,
    output logic             take
);
    logic [LVL_W-1:0] pend_q;
    logic [LVL_W-1:0] mask_field;

    // Pending level follows the request line, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= irq_level;
    end

    // Acceptance: idle, clean boundary, level strictly above the mask.
    always_comb begin
        mask_field = cur_sr[MASK_LSB +: LVL_W];
        take       = idle && boundary && !in_delay_slot && (pend_q > mask_field);
    end

    assign pend_level = pend_q;
endmodule

// File: rtl/irq_ctx_regs.sv
// Holds the context snapshot of an entry and computes stack, vector and result values.
// Assumes: snap is pulsed only when no entry is in progress.
module irq_ctx_regs #(
    parameter int LVL_W    = 4,
    parameter int XLEN     = 32,
    parameter int MASK_LSB = 4,
    parameter int VEC_BASE = 64,
    parameter int WORD_B   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap,
    input  logic [LVL_W-1:0] pend_level,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  cur_sr,
    input  logic [XLEN-1:0]  cur_sp,
    input  logic [XLEN-1:0]  vbr,
    input  logic             fetch_done,
    input  logic [XLEN-1:0]  bus_rdata,
    output logic [LVL_W-1:0] lvl_q,
    output logic [XLEN-1:0]  sr_q,
    output logic [XLEN-1:0]  pc_q,
    output logic [XLEN-1:0]  sp_q,
    output logic [XLEN-1:0]  sr_slot_addr,
    output logic [XLEN-1:0]  pc_slot_addr,
    output logic [XLEN-1:0]  vec_addr,
    output logic [XLEN-1:0]  new_pc,
    output logic [XLEN-1:0]  new_sr,
    output logic [XLEN-1:0]  new_sp
);
    localparam logic [XLEN-1:0] FIELD_MASK = XLEN'(((1 << LVL_W) - 1) << MASK_LSB);
    localparam logic [XLEN-1:0] STEP       = XLEN'(WORD_B);

    logic [XLEN-1:0] vbr_q;
    logic [XLEN-1:0] vec_num;

    // Snapshot of the interrupted context at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
            sr_q  <= '0;
            pc_q  <= '0;
            sp_q  <= '0;
            vbr_q <= '0;
        end else if (snap) begin
            lvl_q <= pend_level;
            sr_q  <= cur_sr;
            pc_q  <= cur_pc;
            sp_q  <= cur_sp;
            vbr_q <= vbr;
        end
    end

    // Pre-decremented stack slots and vector table address.
    always_comb begin
        sr_slot_addr = sp_q - STEP;
        pc_slot_addr = sp_q - (STEP + STEP);
        vec_num      = XLEN'(VEC_BASE) + XLEN'(lvl_q >> 1);
        vec_addr     = vbr_q + vec_num * STEP;
    end

    // Result registers load when the vector read completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_pc <= '0;
            new_sr <= '0;
            new_sp <= '0;
        end else if (fetch_done) begin
            new_pc <= bus_rdata;
            new_sr <= (sr_q & ~FIELD_MASK) | (XLEN'(lvl_q) << MASK_LSB);
            new_sp <= pc_slot_addr;
        end
    end
endmodule

// File: rtl/irq_entry_ctrl.sv
// Sequences ack, SR push, PC push, vector fetch and a fixed tail; drives the bus.
// Assumes: ENTRY_CYCLES >= 5 so that at least one tail cycle exists.
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter int ENTRY_CYCLES = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [XLEN-1:0] sr_slot_addr,
    input  logic [XLEN-1:0] pc_slot_addr,
    input  logic [XLEN-1:0] vec_addr,
    input  logic [XLEN-1:0] sr_q,
    input  logic [XLEN-1:0] pc_q,
    input  logic            bus_ready,
    output logic            idle,
    output logic            busy,
    output logic            ack,
    output logic            done,
    output logic            fetch_done,
    output logic            bus_valid,
    output logic [XLEN-1:0] bus_addr,
    output logic [XLEN-1:0] bus_wdata,
    output logic            bus_we
);
    localparam int TAIL = ENTRY_CYCLES - 4;
    localparam int CW   = (TAIL > 1) ? $clog2(TAIL) : 1;

    entry_state_t    state;
    logic [CW-1:0]   tail_cnt;

    // State sequencing; bus states advance only on ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tail_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE:    if (take) state <= ST_ACK;
                ST_ACK:     state <= ST_PUSH_SR;
                ST_PUSH_SR: if (bus_ready) state <= ST_PUSH_PC;
                ST_PUSH_PC: if (bus_ready) state <= ST_FETCH;
                ST_FETCH: begin
                    if (bus_ready) begin
                        state    <= ST_TAIL;
                        tail_cnt <= CW'(TAIL - 1);
                    end
                end
                ST_TAIL: begin
                    if (tail_cnt == '0) state <= ST_IDLE;
                    else                tail_cnt <= tail_cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus request per state.
    always_comb begin
        bus_valid = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        case (state)
            ST_PUSH_SR: begin
                bus_valid = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = sr_slot_addr;
                bus_wdata = sr_q;
            end
            ST_PUSH_PC: begin
                bus_valid = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = pc_slot_addr;
                bus_wdata = pc_q;
            end
            ST_FETCH: begin
                bus_valid = 1'b1;
                bus_addr  = vec_addr;
            end
            default: ;
        endcase
    end

    // Status decodes.
    always_comb begin
        idle       = (state == ST_IDLE);
        busy       = !idle;
        ack        = (state == ST_ACK);
        done       = (state == ST_TAIL) && (tail_cnt == '0);
        fetch_done = (state == ST_FETCH) && bus_ready;
    end

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we))); // R9

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (!ack && busy)); // R8

    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R8
endmodule

// File: rtl/irq_entry_seq.sv
// Top: level-priority interrupt entry sequencer with a valid/ready bus master.
// Assumes: the core loads new_pc/new_sr/new_sp when done is seen.
module irq_entry_seq #(
    parameter int LVL_W        = 4,
    parameter int XLEN         = 32,
    parameter int MASK_LSB     = 4,
    parameter int VEC_BASE     = 64,
    parameter int ENTRY_CYCLES = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] irq_level,
    input  logic             boundary,
    input  logic             in_delay_slot,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  cur_sr,
    input  logic [XLEN-1:0]  cur_sp,
    input  logic [XLEN-1:0]  vbr,
    output logic             bus_valid,
    output logic [XLEN-1:0]  bus_addr,
    output logic [XLEN-1:0]  bus_wdata,
    output logic             bus_we,
    input  logic             bus_ready,
    input  logic [XLEN-1:0]  bus_rdata,
    output logic             busy,
    output logic             ack,
    output logic [LVL_W-1:0] ack_level,
    output logic             done,
    output logic [XLEN-1:0]  new_pc,
    output logic [XLEN-1:0]  new_sr,
    output logic [XLEN-1:0]  new_sp
);
    logic             idle;
    logic             take;
    logic             fetch_done;
    logic [LVL_W-1:0] pend_level;
    logic [LVL_W-1:0] lvl_q;
    logic [XLEN-1:0]  sr_q, pc_q, sp_q;
    logic [XLEN-1:0]  sr_slot_addr, pc_slot_addr, vec_addr;

    irq_pending_gate #(.LVL_W(LVL_W), .XLEN(XLEN), .MASK_LSB(MASK_LSB)) u_gate (
        .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .boundary(boundary),
        .in_delay_slot(in_delay_slot), .idle(idle), .cur_sr(cur_sr),
        .pend_level(pend_level), .take(take)
    );

    irq_ctx_regs #(.LVL_W(LVL_W), .XLEN(XLEN), .MASK_LSB(MASK_LSB), .VEC_BASE(VEC_BASE)) u_ctx (
        .clk(clk), .rst_n(rst_n), .snap(take), .pend_level(pend_level),
        .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_sp(cur_sp), .vbr(vbr),
        .fetch_done(fetch_done), .bus_rdata(bus_rdata),
        .lvl_q(lvl_q), .sr_q(sr_q), .pc_q(pc_q), .sp_q(sp_q),
        .sr_slot_addr(sr_slot_addr), .pc_slot_addr(pc_slot_addr), .vec_addr(vec_addr),
        .new_pc(new_pc), .new_sr(new_sr), .new_sp(new_sp)
    );

    irq_entry_ctrl #(.XLEN(XLEN), .ENTRY_CYCLES(ENTRY_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .take(take),
        .sr_slot_addr(sr_slot_addr), .pc_slot_addr(pc_slot_addr), .vec_addr(vec_addr),
        .sr_q(sr_q), .pc_q(pc_q), .bus_ready(bus_ready),
        .idle(idle), .busy(busy), .ack(ack), .done(done), .fetch_done(fetch_done),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we)
    );

    // Level is shown only while acknowledging.
    assign ack_level = ack ? lvl_q : '0;

    AST_ENTRY_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(pend_level) > $past(cur_sr[MASK_LSB +: LVL_W]))); // R1

    AST_ENTRY_CLEAN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(boundary && !in_delay_slot)); // R6

    AST_SR_MASK_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_sr[MASK_LSB +: LVL_W] == lvl_q)); // R4

    AST_SP_LOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_sp == sp_q - XLEN'(8))); // R3

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!busy && !ack && !bus_valid)); // R11
endmodule

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_level = '0;
    logic        boundary = 1'b0;
    logic        in_delay_slot = 1'b0;
    logic [31:0] cur_pc = '0, cur_sr = '0, cur_sp = '0, vbr = '0;
    logic        bus_valid, bus_we, bus_ready;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        busy, ack, done;
    logic [3:0]  ack_level;
    logic [31:0] new_pc, new_sr, new_sp;

    int errors = 0;
    int checks = 0;
    int waits = 0;
    int wcnt = 0;
    localparam logic [31:0] RD_KEY = 32'hA5C3_0F11;

    always #2 clk = ~clk;

    irq_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .boundary(boundary),
        .in_delay_slot(in_delay_slot), .cur_pc(cur_pc), .cur_sr(cur_sr),
        .cur_sp(cur_sp), .vbr(vbr), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .busy(busy), .ack(ack), .ack_level(ack_level),
        .done(done), .new_pc(new_pc), .new_sr(new_sr), .new_sp(new_sp)
    );

    // Bus model: ready after 'waits' stall cycles, read data derived from address.
    assign bus_ready = bus_valid && (wcnt == waits);
    assign bus_rdata = bus_addr ^ RD_KEY;
    always @(posedge clk) wcnt <= (bus_valid && !bus_ready) ? wcnt + 1 : 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Observed results of one entry attempt.
    int          o_busy, o_ack, o_wr, o_rd, o_done;
    logic [3:0]  o_lvl;
    logic [31:0] o_wa[2], o_wd[2], o_ra, o_pc, o_sr, o_sp;

    task automatic observe(input int max_cyc, input bit drop_on_ack);
        o_busy = 0; o_ack = 0; o_wr = 0; o_rd = 0; o_done = 0; o_lvl = '0;
        for (int c = 0; c < max_cyc; c++) begin
            @(negedge clk);
            if (busy) o_busy++;
            if (ack) begin
                o_ack++; o_lvl = ack_level;
                if (drop_on_ack) irq_level = '0;
            end
            if (bus_valid && bus_ready) begin
                if (bus_we) begin
                    if (o_wr < 2) begin o_wa[o_wr] = bus_addr; o_wd[o_wr] = bus_wdata; end
                    o_wr++;
                end else begin
                    o_ra = bus_addr; o_rd++;
                end
            end
            if (done) begin
                o_done++; o_pc = new_pc; o_sr = new_sr; o_sp = new_sp;
                break;
            end
        end
    endtask

    task automatic run_case(input logic [3:0] m, input logic [3:0] l, input int w);
        logic [31:0] sr0, pc0, sp0, va;
        bit take;
        waits = w;
        sr0 = (32'h1357_9B0D & ~32'h0000_00F0) | {24'h0, m, 4'h0};
        pc0 = 32'h0600_0000 + {24'h0, l, m};
        sp0 = 32'h0603_F000 - {22'h0, m, 6'h0};
        @(negedge clk);
        cur_sr = sr0; cur_pc = pc0; cur_sp = sp0; vbr = 32'h2000_0400;
        irq_level = l; boundary = 1'b1; in_delay_slot = 1'b0;
        take = (l > m);
        if (take) begin
            observe(40 + 3 * w, 1'b1);
            va = 32'h2000_0400 + (32'd64 + {28'h0, l} / 2) * 4;
            check(o_ack == 1, "R8", "ack count", o_ack, 1);
            check(o_lvl == l, "R8", "ack_level", {28'h0, o_lvl}, {28'h0, l});
            check(o_busy == 13 + 3 * w, "R7", "busy cycles", o_busy, 13 + 3 * w);
            check(o_done == 1, "R8", "done seen", o_done, 1);
            check(o_wr == 2 && o_rd == 1, "R3", "access count", o_wr * 16 + o_rd, 33);
            check(o_wa[0] == sp0 - 4 && o_wd[0] == sr0, "R3", "SR push", o_wa[0], sp0 - 4);
            check(o_wa[1] == sp0 - 8 && o_wd[1] == pc0, "R3", "PC push", o_wa[1], sp0 - 8);
            check(o_ra == va, "R2", "vector addr", o_ra, va);
            check(o_pc == (va ^ RD_KEY), "R5", "new_pc", o_pc, va ^ RD_KEY);
            check(o_sr == ((sr0 & ~32'hF0) | {24'h0, l, 4'h0}), "R4", "new_sr", o_sr,
                  (sr0 & ~32'hF0) | {24'h0, l, 4'h0});
            check(o_sp == sp0 - 8, "R3", "new_sp", o_sp, sp0 - 8);
        end else begin
            observe(6, 1'b0);
            irq_level = '0;
            check(o_busy == 0 && o_ack == 0 && o_wr + o_rd == 0, "R1", "masked level started",
                  o_busy, 0);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hang expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!busy && !ack && !bus_valid && !done, "R11", "reset outputs", {busy, ack, bus_valid, done}, 0);
        check(new_pc == 0 && new_sr == 0 && new_sp == 0, "R11", "reset results", new_pc | new_sr | new_sp, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1..R5, R7, R8: every mask against every level, no waits
        for (int m = 0; m < 16; m++)
            for (int l = 0; l < 16; l++)
                run_case(4'(m), 4'(l), 0);

        // R7, R9: wait states stretch the sequence
        for (int w = 1; w < 4; w++) run_case(4'h2, 4'hB, w);

        // R6: delay slot and no boundary keep the request pending
        waits = 0;
        @(negedge clk);
        cur_sr = 32'h0000_0020; irq_level = 4'h8; boundary = 1'b1; in_delay_slot = 1'b1;
        observe(5, 1'b0);
        check(o_busy == 0, "R6", "taken in delay slot", o_busy, 0);
        boundary = 1'b0; in_delay_slot = 1'b0;
        observe(4, 1'b0);
        check(o_busy == 0, "R6", "taken off boundary", o_busy, 0);
        boundary = 1'b1;
        observe(40, 1'b1);
        check(o_ack == 1 && o_lvl == 4'h8, "R6", "pending taken at clean boundary", {28'h0, o_lvl}, 8);

        // R10: request raised during an entry waits for its end
        @(negedge clk); @(negedge clk);
        cur_sr = 32'h0000_0000; irq_level = 4'h5;
        o_ack = 0;
        begin
            int acks = 0, idle_gap = 0;
            bit seen_done = 0, raised = 0;
            logic [3:0] lv2 = '0;
            for (int c = 0; c < 60; c++) begin
                @(negedge clk);
                if (ack) begin
                    acks++;
                    if (acks == 1) begin irq_level = 4'h9; raised = 1; end
                    else lv2 = ack_level;
                end
                if (raised && busy && !seen_done && acks > 1)
                    check(0, "R10", "second entry during first", acks, 1);
                if (done && !seen_done) begin seen_done = 1; cur_sr = new_sr; end
                else if (seen_done && !busy) idle_gap++;
                if (acks == 2) break;
            end
            check(acks == 2 && lv2 == 4'h9, "R10", "held request taken after entry",
                  {28'h0, lv2}, 9);
            check(idle_gap == 1, "R10", "idle cycles before second entry", idle_gap, 1);
            irq_level = '0;
        end

        // R11: reset during an entry
        observe(5, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !ack && !bus_valid, "R11", "reset mid-entry", {busy, ack, bus_valid}, 0);
        cur_sr = 32'h0; irq_level = 4'h0;
        rst_n = 1'b1;
        observe(4, 1'b0);
        check(o_busy == 0, "R11", "pending cleared", o_busy, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule